// File: doc/BRIEF.md
# Two-Layer Spiking Neuron Array

This block is a small fixed-topology spiking network: a front layer of sixteen leaky integrate-and-fire neurons wired to every one of sixteen back-layer neurons. Each incoming event names one front neuron with a 4-bit index and brings one signed synaptic weight. The weight goes to every front neuron, but only the addressed neuron adds it to its potential. There is no stored connectivity. When a front neuron fires, its index, captured in a register in the same cycle as the event, selects one column of the configured weight matrix in the next cycle. That single spike then reaches all sixteen back neurons at once, each with its own synapse weight.

Weights and thresholds arrive on flat configuration buses that a surrounding memory holds stable. A single external decay strobe leaks all thirty-two potentials together. A new event can be accepted on every clock cycle with no stall. The result is a sixteen-bit vector of single-cycle spike pulses from the back layer.

Top module: `snnTileTop`

## Requirements
- R1: While reset is low and after reset is released, `outSpikes` is all zero and every potential is at rest (zero), so the first event integrates from zero.
- R2: When `inSpike` is high, only the front neuron numbered `inIdx` adds `inWeight` to its potential. When `inSpike` is low, no front neuron integrates.
- R3: A neuron fires only in a cycle in which it receives a spike, and only when its updated potential is strictly greater than its threshold (signed compare). Firing clears the potential to zero. Its spike is a one-cycle pulse on the following cycle.
- R4: A spike from front neuron k is applied in the next cycle to all back neurons. Back neuron j adds the weight at `synWeights[(k*16+j)*WGT_W +: WGT_W]`.
- R5: An event sampled at clock edge t can show up on `outSpikes` only after edge t+1. It needs two register stages.
- R6: When `decayStrobe` is high, every potential in both layers is shifted right by one, arithmetically. If a spike lands in the same cycle, the shift is applied first and then the weight is added.
- R7: Potentials saturate at the most negative and most positive signed `POT_W`-bit values instead of wrapping.
- R8: Events on consecutive cycles at any indices are all accepted. The routing of one event to the back layer overlaps the integration of the next event in the front layer.
- R9: `thresholds[i*POT_W +: POT_W]` is the threshold of front neuron i. `thresholds[(16+j)*POT_W +: POT_W]` is the threshold of back neuron j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inSpike | input | 1 | Event pulse for the front layer |
| inIdx | input | 4 | Index of the addressed front neuron |
| inWeight | input | WGT_W | Signed weight carried with the event |
| decayStrobe | input | 1 | Leak pulse shared by all neurons |
| synWeights | input | 16*16*WGT_W | Signed weight matrix, entry (k,j) at index k*16+j |
| thresholds | input | 32*POT_W | Signed thresholds, front layer first, then back layer |
| outSpikes | output | 16 | Back-layer spike pulses |

## Verification
Two things can happen in the same cycle. A new event can integrate into the front layer while the previous front spike is being routed through its weight column into the back layer. A decay strobe can also land together with either of these. The bench provokes both with back-to-back event sweeps over all sixteen indices and with a long stretch of random events and random decay strobes. It judges every cycle against an arithmetic model of the thirty-two potentials. That model applies the shift-then-add order and the one-cycle routing offset.

// File: rtl/snnPkg.sv
package snnPkg;
  localparam int NEUR  = 16;
  localparam int IDX_W = $clog2(NEUR);

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic [NEUR-1:0]  l1Sel;   // one-hot integrate enable, front layer
    logic [IDX_W-1:0] colIdx;  // registered index of last addressed neuron
    logic             decay;   // shared leak pulse
  } snnStrobeT;
endpackage

// File: rtl/snnNeuron.sv
module snnNeuron #(
  parameter int POT_W = 16,
  parameter int WGT_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    spikeIn,
  input  logic                    decay,
  input  logic signed [WGT_W-1:0] weight,
  input  logic signed [POT_W-1:0] thr,
  output logic                    spikeOut
);
  localparam logic signed [POT_W-1:0] POT_MAX = {1'b0, {(POT_W-1){1'b1}}};
  localparam logic signed [POT_W-1:0] POT_MIN = {1'b1, {(POT_W-1){1'b0}}};

  logic signed [POT_W-1:0] pot;
  logic signed [POT_W-1:0] base;
  logic signed [POT_W-1:0] satSum;
  logic        [POT_W:0]   sum;
  logic                    fire;

  always_comb begin
    base = decay ? (pot >>> 1) : pot;
    sum  = {base[POT_W-1], base} + {{(POT_W+1-WGT_W){weight[WGT_W-1]}}, weight};
    if (sum[POT_W] != sum[POT_W-1])
      satSum = sum[POT_W] ? POT_MIN : POT_MAX;
    else
      satSum = sum[POT_W-1:0];
    fire = spikeIn && (satSum > thr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pot      <= '0;
      spikeOut <= 1'b0;
    end else begin
      spikeOut <= fire;
      if (fire)         pot <= '0;
      else if (spikeIn) pot <= satSum;
      else              pot <= base;
    end
  end
endmodule

// File: rtl/snnCtrl.sv
module snnCtrl
  import snnPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inSpike,
  input  logic [IDX_W-1:0] inIdx,
  input  logic             decayStrobe,
  output snnStrobeT        strobe
);
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        idxQ <= '0;
    else if (inSpike) idxQ <= inIdx;
  end

  for (genvar i = 0; i < NEUR; i++) begin : g_dec
    assign strobe.l1Sel[i] = inSpike && (inIdx == IDX_W'(i));
  end

  assign strobe.colIdx = idxQ;
  assign strobe.decay  = decayStrobe;
endmodule

// File: rtl/snnData.sv
module snnData
  import snnPkg::*;
#(
  parameter int POT_W = 16,
  parameter int WGT_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  snnStrobeT                  strobe,
  input  logic [WGT_W-1:0]           inWeight,
  input  logic [NEUR*NEUR*WGT_W-1:0] synWeights,
  input  logic [2*NEUR*POT_W-1:0]    thresholds,
  output logic [NEUR-1:0]            l1Spikes,
  output logic [NEUR-1:0]            outSpikes
);
  logic [WGT_W-1:0] colW [NEUR];
  logic             l2Drive;

  for (genvar i = 0; i < NEUR; i++) begin : g_l1
    snnNeuron #(.POT_W(POT_W), .WGT_W(WGT_W)) u_n (
      .clk     (clk),
      .rstN    (rstN),
      .spikeIn (strobe.l1Sel[i]),
      .decay   (strobe.decay),
      .weight  (inWeight),
      .thr     (thresholds[i*POT_W +: POT_W]),
      .spikeOut(l1Spikes[i])
    );
  end

  // at most one front neuron fires per cycle; its index selects the column
  assign l2Drive = l1Spikes[strobe.colIdx];

  always_comb begin
    for (int j = 0; j < NEUR; j++)
      colW[j] = synWeights[(int'(strobe.colIdx)*NEUR + j)*WGT_W +: WGT_W];
  end

  for (genvar j = 0; j < NEUR; j++) begin : g_l2
    snnNeuron #(.POT_W(POT_W), .WGT_W(WGT_W)) u_n (
      .clk     (clk),
      .rstN    (rstN),
      .spikeIn (l2Drive),
      .decay   (strobe.decay),
      .weight  (colW[j]),
      .thr     (thresholds[(NEUR+j)*POT_W +: POT_W]),
      .spikeOut(outSpikes[j])
    );
  end
endmodule

// File: rtl/snnTileTop.sv
module snnTileTop
  import snnPkg::*;
#(
  parameter int WGT_W = 8,
  parameter int POT_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inSpike,
  input  logic [IDX_W-1:0]           inIdx,
  input  logic [WGT_W-1:0]           inWeight,
  input  logic                       decayStrobe,
  input  logic [NEUR*NEUR*WGT_W-1:0] synWeights,
  input  logic [2*NEUR*POT_W-1:0]    thresholds,
  output logic [NEUR-1:0]            outSpikes
);
  snnStrobeT       strobe;
  logic [NEUR-1:0] l1Spikes;

  snnCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inSpike    (inSpike),
    .inIdx      (inIdx),
    .decayStrobe(decayStrobe),
    .strobe     (strobe)
  );

  snnData #(.POT_W(POT_W), .WGT_W(WGT_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inWeight  (inWeight),
    .synWeights(synWeights),
    .thresholds(thresholds),
    .l1Spikes  (l1Spikes),
    .outSpikes (outSpikes)
  );
endmodule

// File: rtl/snnTileChk.sv
module snnTileChk
  import snnPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inSpike,
  input logic [IDX_W-1:0] inIdx,
  input logic [NEUR-1:0]  l1Spikes,
  input logic [NEUR-1:0]  outSpikes
);
  // R3
  l1_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(l1Spikes));

  // R3
  l1_needs_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (l1Spikes != '0) |-> $past(inSpike));

  // R2
  l1_addressed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (l1Spikes != '0) |-> (l1Spikes == (NEUR'(1) << $past(inIdx))));

  // R5
  out_after_front_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outSpikes != '0) |-> ($past(l1Spikes) != '0));
endmodule

bind snnTileTop snnTileChk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inSpike  (inSpike),
  .inIdx    (inIdx),
  .l1Spikes (l1Spikes),
  .outSpikes(outSpikes)
);

// File: tb/snnTileTop_bench.sv
module snnTileTop_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int WW = 8;
  localparam int PW = 16;
  localparam int PMAX = 32767;
  localparam int PMIN = -32768;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inSpike = 1'b0;
  logic [3:0] inIdx = '0;
  logic [WW-1:0] inWeight = '0;
  logic decayStrobe = 1'b0;
  logic [N*N*WW-1:0] synWeights = '0;
  logic [2*N*PW-1:0] thresholds = '0;
  logic [N-1:0] outSpikes;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int wt [N][N];
  int thr1 [N];
  int thr2 [N];
  int pot1 [N];
  int pot2 [N];
  int pend = -1;
  logic [N-1:0] expOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  snnTileTop #(.WGT_W(WW), .POT_W(PW)) u_snnTileTop (
    .clk(clk), .rstN(rstN), .inSpike(inSpike), .inIdx(inIdx),
    .inWeight(inWeight), .decayStrobe(decayStrobe),
    .synWeights(synWeights), .thresholds(thresholds), .outSpikes(outSpikes)
  );

  function automatic int sat(int v);
    if (v > PMAX) return PMAX;
    if (v < PMIN) return PMIN;
    return v;
  endfunction

  task automatic applyCfg();
    for (int k = 0; k < N; k++)
      for (int j = 0; j < N; j++)
        synWeights[(k*N+j)*WW +: WW] = WW'(wt[k][j]);
    for (int i = 0; i < N; i++) begin
      thresholds[i*PW +: PW]     = PW'(thr1[i]);
      thresholds[(N+i)*PW +: PW] = PW'(thr2[i]);
    end
  endtask

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outSpikes=%h expected=%h", tag, act, exp);
    end
  endtask

  // model step, applied at the clock edge that samples the inputs
  task automatic modelStep(bit spk, int idx, int w, bit dec);
    int b, n, np;
    expOut = '0;
    for (int j = 0; j < N; j++) begin
      b = dec ? (pot2[j] >>> 1) : pot2[j];
      if (pend >= 0) begin
        n = sat(b + wt[pend][j]);
        if (n > thr2[j]) begin expOut[j] = 1'b1; pot2[j] = 0; end
        else pot2[j] = n;
      end else pot2[j] = b;
    end
    np = -1;
    for (int i = 0; i < N; i++) begin
      b = dec ? (pot1[i] >>> 1) : pot1[i];
      if (spk && i == idx) begin
        n = sat(b + w);
        if (n > thr1[i]) begin np = i; pot1[i] = 0; end
        else pot1[i] = n;
      end else pot1[i] = b;
    end
    pend = np;
  endtask

  // called at a falling edge; drives, waits one edge, checks at next fall
  task automatic cyc(bit spk, int idx, int w, bit dec, string tag);
    inSpike = spk; inIdx = 4'(idx); inWeight = WW'(w); decayStrobe = dec;
    @(posedge clk);
    modelStep(spk, idx, w, dec);
    @(negedge clk);
    check(tag, outSpikes, expOut);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    tests++; fails++;
    $display("FAIL watchdog: outSpikes=%h expected=done", outSpikes);
    finish();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      pot1[i] = 0; pot2[i] = 0; thr1[i] = 0; thr2[i] = 40;
      for (int j = 0; j < N; j++) wt[i][j] = ((i*5 + j*3) % 11) * 9 - 30;
    end
    applyCfg();
    repeat (4) @(negedge clk);
    check("R1 in reset", outSpikes, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", outSpikes, '0);

    // R8 R4 R5: back-to-back sweep of all indices
    for (int k = 0; k < N; k++) cyc(1, k, 10, 0, "R8 back-to-back sweep");
    repeat (3) cyc(0, 0, 0, 0, "R5 drain");
    // R4: spaced sweep, reversed order
    for (int k = N-1; k >= 0; k--) begin
      cyc(1, k, 5, 0, "R4 column route");
      cyc(0, 0, 0, 0, "R4 column route");
      cyc(0, 0, 0, 0, "R5 latency");
    end

    // R2: negative weight, no fire; idle spikes ignored
    cyc(1, 3, -5, 0, "R2 addressed only");
    cyc(0, 3, 100, 0, "R2 no event");
    cyc(1, 3, 6, 0, "R2 addressed only");
    repeat (2) cyc(0, 0, 0, 0, "R2 drain");

    // R9 R3: per-neuron thresholds
    for (int i = 0; i < N; i++) begin thr1[i] = i * 4; thr2[i] = 10 + i * 3; end
    applyCfg();
    for (int k = 0; k < N; k++) begin
      cyc(1, k, 30, 0, "R9 threshold layout");
      cyc(1, k, 30, 0, "R3 fire and clear");
    end
    repeat (3) cyc(0, 0, 0, 0, "R3 drain");

    // R6: decay order with coincident spike
    thr1[2] = 100; applyCfg();
    cyc(1, 2, 60, 0, "R6 decay");
    cyc(0, 0, 0, 1, "R6 decay");
    cyc(1, 2, 60, 0, "R6 decay no fire");
    cyc(1, 2, 60, 1, "R6 shift then add");
    cyc(1, 2, 60, 1, "R6 shift then add");
    repeat (3) cyc(0, 0, 0, 1, "R6 shared decay");

    // R7: negative saturation, then recovery must not fire
    thr1[5] = 0; applyCfg();
    for (int n = 0; n < 300; n++) cyc(1, 5, -128, 0, "R7 saturate low");
    for (int n = 0; n < 200; n++) cyc(1, 5, 127, 0, "R7 climb from floor");
    repeat (2) cyc(0, 0, 0, 0, "R7 drain");

    // R8 R6: random traffic
    for (int i = 0; i < N; i++) begin
      thr1[i] = int'($urandom_range(200));
      thr2[i] = int'($urandom_range(200)) - 50;
      for (int j = 0; j < N; j++) wt[i][j] = int'($urandom_range(200)) - 100;
    end
    applyCfg();
    for (int n = 0; n < 600; n++)
      cyc(bit'($urandom_range(3) != 0), int'($urandom_range(15)),
          int'($urandom_range(255)) - 128, bit'($urandom_range(7) == 0),
          "R8 random overlap");
    repeat (3) cyc(0, 0, 0, 0, "R8 drain");
    finish();
  end
endmodule